// File: doc/BRIEF.md
# Tester Pin Waveform Formatter

This block sits at the end of one tester channel and turns a stream of pattern bits, one per tester cycle, into a timed drive waveform for a single device pin. It runs on a fast tick clock. A tester cycle lasts a programmable number of ticks, and two edge offsets, counted in ticks from the start of the cycle, place the transitions inside it. A three-bit format code picks one of six waveform shapes. The shapes are pulse-high, pulse-low, plain level, delayed level, complement-surround and tri-state control.

Both outputs are registered: a logic level for the pin driver and an enable, where an inactive enable means the pin is released to high impedance. Pattern bits arrive through a ready/valid handshake that is open only on the first tick of each cycle (T0). Format, edges and period are taken at T0 and hold for the whole cycle. If no bit is offered at T0, the cycle plays the format's resting waveform and an underrun flag is raised for that cycle.

Top module: `pin_wave_formatter`

## Requirements
- R1: A tick counter runs from 0 to P-1 and wraps, where P is the period sampled at T0 (count 0). A period value below 2 is treated as 2.
- R2: `pat_ready` is high exactly on T0 ticks and low during reset. A bit is taken when `pat_valid` and `pat_ready` are both high at a rising clock edge.
- R3: Format 0 (pulse-high): the pin is low, except that a data 1 drives it high for the ticks with edge_a <= count < edge_b.
- R4: Format 1 (pulse-low): the pin is high, except that a data 0 drives it low for the ticks with edge_a <= count < edge_b.
- R5: Format 2 (plain level): the data bit is driven for the whole cycle. The edges have no effect.
- R6: Format 3 (delayed level): the previously accepted bit is held for counts below edge_a. From edge_a to the end of the cycle, the new bit is driven.
- R7: Format 4 (complement-surround): the complement of the data is driven from T0. The true data is driven for edge_a <= count < edge_b, and the complement again from edge_b.
- R8: In formats 0, 1 and 4, if edge_b <= edge_a the window is empty. Format 0 then stays low, format 1 stays high, and format 4 drives the complement for the whole cycle.
- R9: Format 5 (tri-state control): the enable follows the data bit (1 = driven) and the level is 0. In formats 0 to 4 the enable is high.
- R10: Format codes 6 and 7 release the pin: enable 0, level 0.
- R11: Format, edges and period are sampled only at T0. A change made in the middle of a cycle takes effect from the next T0.
- R12: When no bit is valid at T0, `underrun` is 1 for that whole cycle and the cycle uses its resting waveform: low for formats 0 and 4, high for format 1, the last accepted bit for formats 2 and 3, and released for format 5.
- R13: While `rst` is high, `pin_drive`, `pin_enable` and `underrun` are 0.
- R14: The outputs are registered. The value computed for count k appears after the clock edge at which the counter holds k, so each edge shows one tick after its programmed offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fmt | input | 3 | Waveform format code |
| cfg_period | input | 8 | Cycle length in ticks |
| cfg_edge_a | input | 8 | First edge offset in ticks |
| cfg_edge_b | input | 8 | Second edge offset in ticks |
| pat_valid | input | 1 | Pattern bit offered |
| pat_bit | input | 1 | Pattern bit value |
| pat_ready | output | 1 | Pattern bit taken this tick (T0) |
| pin_drive | output | 1 | Registered drive level |
| pin_enable | output | 1 | Registered drive enable, 0 = high impedance |
| underrun | output | 1 | No bit was supplied for the current cycle |

## Verification
The bench pushes inverted edge pairs (equal and reversed) through both pulse formats and complement-surround. A design that opened a wrapped window there would emit a stray pulse. Delayed-level runs use edge_a at 0 and at the last tick. A design that picked the wrong held bit would show the old value for too long or change too early. Configuration changes are made mid-cycle, and the period is set to 0 and to short values. A design that applied settings at once would distort the running cycle, and one that wrapped the counter wrongly would lose the T0 alignment. Gaps in the bit supply check that each format falls back to its own resting level and that the underrun flag covers exactly one cycle.

// File: rtl/pinfmt_pkg.sv
package pinfmt_pkg;

    localparam int TICK_W = 8;

    typedef enum logic [2:0] {
        FMT_RZ   = 3'd0,
        FMT_RO   = 3'd1,
        FMT_NRZ  = 3'd2,
        FMT_DNRZ = 3'd3,
        FMT_SBC  = 3'd4,
        FMT_ZD   = 3'd5,
        FMT_RSV6 = 3'd6,
        FMT_RSV7 = 3'd7
    } fmt_e;

    // Everything that shapes one tester cycle, frozen at T0.
    typedef struct packed {
        fmt_e              fmt;
        logic [TICK_W-1:0] edge_a;
        logic [TICK_W-1:0] edge_b;
        logic              present;
        logic              bit_val;
    } cycle_ctx_t;

    typedef struct packed {
        logic drive;
        logic enable;
    } pin_out_t;

    function automatic logic in_window(input logic [TICK_W-1:0] a,
                                       input logic [TICK_W-1:0] b,
                                       input logic [TICK_W-1:0] k);
        return (a < b) && (k >= a) && (k < b);
    endfunction

    // Pin state for tick k of a cycle described by c; hold is the
    // last bit accepted before this cycle.
    function automatic pin_out_t shape_tick(input cycle_ctx_t        c,
                                            input logic              hold,
                                            input logic [TICK_W-1:0] k);
        pin_out_t o;
        logic     win;
        win      = in_window(c.edge_a, c.edge_b, k);
        o.enable = 1'b1;
        o.drive  = 1'b0;
        case (c.fmt)
            FMT_RZ:   o.drive  = c.present & c.bit_val & win;
            FMT_RO:   o.drive  = ~(c.present & ~c.bit_val & win);
            FMT_NRZ:  o.drive  = c.present ? c.bit_val : hold;
            FMT_DNRZ: o.drive  = (c.present && (k >= c.edge_a)) ? c.bit_val : hold;
            FMT_SBC:  o.drive  = c.present & (win ? c.bit_val : ~c.bit_val);
            FMT_ZD:   o.enable = c.present & c.bit_val;
            default:  o.enable = 1'b0;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/pinfmt_timer.sv
module pinfmt_timer
    import pinfmt_pkg::*;
#(
    parameter int MIN_PERIOD = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TICK_W-1:0] cfg_period,
    output logic [TICK_W-1:0] tick_cnt,
    output logic              at_t0
);

    localparam logic [TICK_W-1:0] MIN_P = TICK_W'(MIN_PERIOD);

    logic [TICK_W-1:0] per_q;
    logic [TICK_W-1:0] per_req;
    logic [TICK_W-1:0] per_eff;
    logic              last_tick;

    assign at_t0     = (tick_cnt == '0);
    assign per_req   = (cfg_period < MIN_P) ? MIN_P : cfg_period;
    assign per_eff   = at_t0 ? per_req : per_q;
    assign last_tick = (tick_cnt == per_eff - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_cnt <= '0;
            per_q    <= MIN_P;
        end else begin
            if (at_t0) begin
                per_q <= per_req;
            end
            tick_cnt <= last_tick ? '0 : tick_cnt + 1'b1;
        end
    end

    AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (rst)
        !at_t0 |-> (tick_cnt < per_q));                                  // R1

    AST_T0_NOT_TWICE: assert property (@(posedge clk) disable iff (rst)
        at_t0 |=> !at_t0);                                               // R1

endmodule

// File: rtl/pinfmt_context.sv
module pinfmt_context
    import pinfmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              at_t0,
    input  logic [2:0]        cfg_fmt,
    input  logic [TICK_W-1:0] cfg_edge_a,
    input  logic [TICK_W-1:0] cfg_edge_b,
    input  logic              pat_valid,
    input  logic              pat_bit,
    output logic              pat_ready,
    output cycle_ctx_t        ctx,
    output logic              hold_bit
);

    cycle_ctx_t ctx_q;
    cycle_ctx_t fresh;
    logic       hold_q;
    logic       hold_next;

    assign pat_ready = at_t0 & ~rst;

    always_comb begin
        fresh.fmt     = fmt_e'(cfg_fmt);
        fresh.edge_a  = cfg_edge_a;
        fresh.edge_b  = cfg_edge_b;
        fresh.present = pat_valid;
        fresh.bit_val = pat_bit;
    end

    // Last accepted bit, including the one of the cycle now ending.
    assign hold_next = ctx_q.present ? ctx_q.bit_val : hold_q;

    assign ctx      = at_t0 ? fresh : ctx_q;
    assign hold_bit = at_t0 ? hold_next : hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q.fmt     <= FMT_RZ;
            ctx_q.edge_a  <= '0;
            ctx_q.edge_b  <= '0;
            ctx_q.present <= 1'b0;
            ctx_q.bit_val <= 1'b0;
            hold_q        <= 1'b0;
        end else if (at_t0) begin
            ctx_q  <= fresh;
            hold_q <= hold_next;
        end
    end

    AST_CTX_FROZEN_MIDCYCLE: assert property (@(posedge clk) disable iff (rst)
        !at_t0 |=> $stable(ctx.fmt) || $past(at_t0) == 1'b0 && at_t0);  // R11

endmodule

// File: rtl/pinfmt_shaper.sv
module pinfmt_shaper
    import pinfmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              at_t0,
    input  cycle_ctx_t        ctx,
    input  logic              hold_bit,
    input  logic [TICK_W-1:0] tick_cnt,
    output logic              pin_drive,
    output logic              pin_enable,
    output logic              underrun
);

    pin_out_t nxt;

    assign nxt = shape_tick(ctx, hold_bit, tick_cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_drive  <= 1'b0;
            pin_enable <= 1'b0;
            underrun   <= 1'b0;
        end else begin
            pin_drive  <= nxt.drive;
            pin_enable <= nxt.enable;
            if (at_t0) begin
                underrun <= ~ctx.present;
            end
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!pin_enable && !pin_drive && !underrun));               // R13

    AST_NRZ_FLAT: assert property (@(posedge clk) disable iff (rst)
        (!at_t0 && ctx.fmt == FMT_NRZ) |=> $stable(pin_drive));          // R5

    AST_DRIVEN_FORMATS: assert property (@(posedge clk) disable iff (rst)
        (!at_t0 && ctx.fmt inside {FMT_RZ, FMT_RO, FMT_NRZ, FMT_DNRZ, FMT_SBC})
        |=> pin_enable);                                                 // R9

    AST_BAD_CODE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (!at_t0 && ctx.fmt inside {FMT_RSV6, FMT_RSV7}) |=> !pin_enable); // R10

    AST_UNDERRUN_HELD: assert property (@(posedge clk) disable iff (rst)
        !at_t0 |=> $stable(underrun));                                   // R12

endmodule

// File: rtl/pin_wave_formatter.sv
module pin_wave_formatter
    import pinfmt_pkg::*;
#(
    parameter int MIN_PERIOD = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cfg_fmt,
    input  logic [TICK_W-1:0] cfg_period,
    input  logic [TICK_W-1:0] cfg_edge_a,
    input  logic [TICK_W-1:0] cfg_edge_b,
    input  logic              pat_valid,
    input  logic              pat_bit,
    output logic              pat_ready,
    output logic              pin_drive,
    output logic              pin_enable,
    output logic              underrun
);

    logic [TICK_W-1:0] tick_cnt;
    logic              at_t0;
    cycle_ctx_t        ctx;
    logic              hold_bit;

    pinfmt_timer #(
        .MIN_PERIOD (MIN_PERIOD)
    ) timer_i (
        .clk        (clk),
        .rst        (rst),
        .cfg_period (cfg_period),
        .tick_cnt   (tick_cnt),
        .at_t0      (at_t0)
    );

    pinfmt_context ctx_i (
        .clk        (clk),
        .rst        (rst),
        .at_t0      (at_t0),
        .cfg_fmt    (cfg_fmt),
        .cfg_edge_a (cfg_edge_a),
        .cfg_edge_b (cfg_edge_b),
        .pat_valid  (pat_valid),
        .pat_bit    (pat_bit),
        .pat_ready  (pat_ready),
        .ctx        (ctx),
        .hold_bit   (hold_bit)
    );

    pinfmt_shaper shaper_i (
        .clk        (clk),
        .rst        (rst),
        .at_t0      (at_t0),
        .ctx        (ctx),
        .hold_bit   (hold_bit),
        .tick_cnt   (tick_cnt),
        .pin_drive  (pin_drive),
        .pin_enable (pin_enable),
        .underrun   (underrun)
    );

    AST_READY_ONE_TICK: assert property (@(posedge clk) disable iff (rst)
        pat_ready |=> !pat_ready);                                       // R2

endmodule

// File: tb/pin_wave_formatter_tb_top.sv
module pin_wave_formatter_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] cfg_fmt;
    logic [7:0] cfg_period;
    logic [7:0] cfg_edge_a;
    logic [7:0] cfg_edge_b;
    logic       pat_valid;
    logic       pat_bit;
    logic       pat_ready;
    logic       pin_drive;
    logic       pin_enable;
    logic       underrun;

    always #10 clk = ~clk;

    pin_wave_formatter dut_i (
        .clk        (clk),
        .rst        (rst),
        .cfg_fmt    (cfg_fmt),
        .cfg_period (cfg_period),
        .cfg_edge_a (cfg_edge_a),
        .cfg_edge_b (cfg_edge_b),
        .pat_valid  (pat_valid),
        .pat_bit    (pat_bit),
        .pat_ready  (pat_ready),
        .pin_drive  (pin_drive),
        .pin_enable (pin_enable),
        .underrun   (underrun)
    );

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Reference model state
    int mk, m_per, m_fmt, m_a, m_b;
    bit m_pres, m_d, m_hold, last_bit, m_under, mid_flag;
    bit q[$];

    function automatic void model(output bit dv, output bit en);
        bit w;
        w  = (m_a < m_b) && (mk >= m_a) && (mk < m_b);
        en = 1;
        dv = 0;
        if (m_fmt == 0)      dv = m_pres && m_d && w;
        else if (m_fmt == 1) dv = !(m_pres && !m_d && w);
        else if (m_fmt == 2) dv = m_pres ? m_d : m_hold;
        else if (m_fmt == 3) dv = (m_pres && mk >= m_a) ? m_d : m_hold;
        else if (m_fmt == 4) dv = m_pres ? (w ? m_d : !m_d) : 0;
        else if (m_fmt == 5) en = m_pres && m_d;
        else                 en = 0;
    endfunction

    function automatic string tag_of();
        string s;
        if (m_fmt > 5)        s = "R10";
        else if (!m_pres)     s = "R12";
        else if (m_fmt == 0)  s = "R3";
        else if (m_fmt == 1)  s = "R4";
        else if (m_fmt == 2)  s = "R5";
        else if (m_fmt == 3)  s = "R6";
        else if (m_fmt == 4)  s = "R7";
        else                  s = "R9";
        if ((m_fmt == 0 || m_fmt == 1 || m_fmt == 4) && m_a >= m_b) s = {s, " R8"};
        if (mid_flag) s = {s, " R11"};
        return {s, " R14"};
    endfunction

    task automatic tick();
        bit ed, ee;
        if (mk == 0 && q.size() > 0) begin
            pat_valid = 1; pat_bit = q[0];
        end else begin
            pat_valid = 0; pat_bit = 0;
        end
        #1;
        n_run++;
        if (pat_ready !== (mk == 0)) begin
            n_fail++;
            $display("FAIL R1 R2 ready at count %0d: actual %b expected %b", mk, pat_ready, mk == 0);
        end
        if (mk == 0) begin
            m_fmt  = cfg_fmt;
            m_a    = cfg_edge_a;
            m_b    = cfg_edge_b;
            m_per  = (cfg_period < 2) ? 2 : cfg_period;
            m_pres = pat_valid;
            m_d    = pat_bit;
            m_hold = last_bit;
            if (pat_valid) begin
                last_bit = pat_bit;
                void'(q.pop_front());
            end
            m_under  = !pat_valid;
            mid_flag = 0;
        end
        model(ed, ee);
        @(posedge clk);
        @(negedge clk);
        n_run++;
        if ({pin_drive, pin_enable, underrun} !== {ed, ee, m_under}) begin
            n_fail++;
            $display("FAIL %s fmt %0d count %0d: actual drv/en/und %b%b%b expected %b%b%b",
                     tag_of(), m_fmt, mk, pin_drive, pin_enable, underrun, ed, ee, m_under);
        end
        mk = (mk == m_per - 1) ? 0 : mk + 1;
        pat_valid = 0;
    endtask

    task automatic run_cycles(input int n);
        for (int c = 0; c < n; c++) begin
            tick();
            while (mk != 0) tick();
        end
    endtask

    task automatic set_cfg(input int f, input int per, input int a, input int b);
        cfg_fmt = 3'(f); cfg_period = 8'(per); cfg_edge_a = 8'(a); cfg_edge_b = 8'(b);
    endtask

    task automatic push(input bit b);
        q.push_back(b);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired: actual running expected finished");
        finish_run();
    end

    initial begin
        rst = 1; pat_valid = 0; pat_bit = 0;
        set_cfg(0, 8, 2, 5);
        mk = 0; m_per = 2; last_bit = 0; mid_flag = 0;
        // R13: quiet outputs while in reset
        repeat (4) begin
            @(negedge clk);
            n_run++;
            if ({pin_drive, pin_enable, underrun, pat_ready} !== 4'b0000) begin
                n_fail++;
                $display("FAIL R13 reset outputs: actual %b%b%b%b expected 0000",
                         pin_drive, pin_enable, underrun, pat_ready);
            end
        end
        rst = 0;

        // R3 pulse-high, then two cycles with no data (R12)
        set_cfg(0, 8, 2, 5);
        push(1); push(0); push(1); push(1); push(0);
        run_cycles(7);
        // R4 pulse-low
        set_cfg(1, 8, 2, 5);
        push(0); push(1); push(0); push(0); push(1);
        run_cycles(6);
        // R5 plain level with one underrun cycle holding the last bit
        set_cfg(2, 8, 2, 5);
        push(1); push(1); push(0); push(1);
        run_cycles(5);
        // R6 delayed level at several offsets
        set_cfg(3, 8, 3, 0);
        push(0); push(1); push(1); push(0); push(1);
        run_cycles(6);
        set_cfg(3, 8, 0, 0);
        push(0); push(1);
        run_cycles(2);
        set_cfg(3, 8, 7, 0);
        push(0); push(1); push(0);
        run_cycles(3);
        // R7 complement-surround
        set_cfg(4, 8, 2, 6);
        push(1); push(0); push(1);
        run_cycles(4);
        // R8 empty windows
        set_cfg(4, 8, 5, 2);
        push(1); push(0);
        run_cycles(2);
        set_cfg(0, 8, 5, 5);
        push(1);
        run_cycles(1);
        set_cfg(1, 8, 6, 1);
        push(0);
        run_cycles(1);
        // R9 tri-state control
        set_cfg(5, 8, 2, 5);
        push(1); push(0); push(1); push(1); push(0);
        run_cycles(6);
        // R10 reserved codes
        set_cfg(6, 6, 1, 3);
        push(1); push(0);
        run_cycles(2);
        set_cfg(7, 6, 1, 3);
        push(1);
        run_cycles(1);
        // R1 other periods, including a clamped zero
        set_cfg(0, 5, 0, 4);
        push(1); push(1); push(0);
        run_cycles(3);
        set_cfg(1, 0, 0, 1);
        push(0); push(1); push(0);
        run_cycles(3);
        set_cfg(4, 1, 1, 2);
        push(1); push(0);
        run_cycles(2);
        // R11 mid-cycle reconfiguration is deferred to the next T0
        set_cfg(0, 8, 1, 6);
        push(1); push(1); push(0);
        tick(); tick(); tick();
        set_cfg(4, 6, 3, 4);
        mid_flag = 1;
        while (mk != 0) tick();
        run_cycles(2);
        tick(); tick();
        set_cfg(2, 9, 0, 0);
        mid_flag = 1;
        while (mk != 0) tick();
        push(1);
        run_cycles(2);

        finish_run();
    end

endmodule